// File: doc/BRIEF.md
# Hierarchical Pattern Sequence Generator

This block plays back a 256-step event stream that is stored compactly as a tree of small shared tables. There are four tiers. Each tier holds eight groups of four one-byte entries. An entry in one of the upper three tiers names a group in the tier directly below it. An entry in the bottom tier holds a 4-bit note. A bottom group is a four-beat bar. One group in the tier above it chains four bars. The next tier chains four of those, which gives sixteen bars. A top group chains four of those again, which gives 64 bars or 256 beats. Because groups are shared, the complete score fits in 128 bytes.

The whole playback position is kept in one 8-bit step counter. Each step request starts a walk from the chosen top group down to one note. The walk runs through four pipeline stages, one per tier, and each tier has its own table, so a new step can be accepted on every cycle. A step request sampled on a rising edge produces its strobe and note right after the fourth rising edge, counting the sampling edge as the first. Software or a host loads the tables through a write port that is addressed by tier, group and entry.

Top module: `hier_seq_gen`

## Requirements
- R1: Reset clears the step counter and the pipeline. While reset is held and afterwards, until a step is played, beat_strobe_o and note_valid_o are 0 and note_o is 0. The first step after reset plays position 0.
- R2: A step_en_i sampled high on a rising edge makes beat_strobe_o high for exactly one cycle, after the fourth rising edge counting the sampling edge as the first. beat_strobe_o never pulses without a step request.
- R3: The 8-bit position is decoded as follows. Bits [7:6] pick the entry in the selected top (tier 3) group. Bits [5:4] pick the entry in the tier 2 group named by that entry. Bits [3:2] pick the entry in the tier 1 group named next. Bits [1:0] pick the beat in the tier 0 bar named last. note_o is that beat's bits [3:0].
- R4: A note value of 0 is a rest. On a rest, beat_strobe_o still pulses, note_valid_o stays 0 and note_o is 0. For a nonzero note, note_valid_o is high together with the strobe.
- R5: Only bits [2:0] of a tier 1 to 3 entry act as a group pointer, and only bits [3:0] of a tier 0 entry act as a note. All upper bits have no effect on the output.
- R6: score_sel_i (3 bits) names the top group and is sampled together with step_en_i. It can change from one step to the next.
- R7: Each step advances the position by one. After 255 the position wraps to 0 and playback continues.
- R8: A write with wr_en_i stores wr_data_i at tier wr_level_i (0 = notes, 3 = top), group wr_group_i, entry wr_entry_i. No other entry changes.
- R9: Step requests on consecutive cycles give one result per cycle, in order.
- R10: When step_en_i is low the position holds, so gaps between steps skip no notes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_en_i | input | 1 | Play the current position and advance |
| score_sel_i | input | 3 | Top-tier group used as the score |
| wr_en_i | input | 1 | Table write strobe |
| wr_level_i | input | 2 | Tier to write (0 = notes, 3 = top) |
| wr_group_i | input | 3 | Group within the tier |
| wr_entry_i | input | 2 | Entry within the group |
| wr_data_i | input | 8 | Entry value |
| beat_strobe_o | output | 1 | One-cycle pulse per played step |
| note_valid_o | output | 1 | Strobe with a non-rest note |
| note_o | output | 4 | Note value of the played step |

## Verification
The bench goes after four corner cases, and for each it states what a faulty design would do.

The position wraps from 255 to 0 in the middle of a run. A design that stopped at 255 or skipped steps there would replay the wrong notes afterwards.

Steps arrive with gaps, and the score changes from one step to the next. A design that advanced the position while idle, or took score_sel_i at the wrong cycle, would shift the whole note stream.

Rests and pointers carry nonzero upper bits. These catch a design that uses the full byte as an index or a note, and a design that treats a rest as valid.

Reset is applied while notes are still in the pipeline. A design that did not clear the pipeline would emit stale strobes, and one that did not clear the counter would not restart at position 0.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  // Default geometry of the pattern tree.
  localparam int HSG_LEVELS  = 4;  // tiers in the tree
  localparam int HSG_FANOUT  = 4;  // entries per group
  localparam int HSG_GROUPS  = 8;  // groups per tier
  localparam int HSG_ENTRY_W = 8;  // stored entry width
  localparam int HSG_NOTE_W  = 4;  // note field width
endpackage

// File: rtl/hsg_step_ctr.sv
module hsg_step_ctr #(
  parameter int POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_en_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (step_en_i) begin
      pos_d = pos_q + POS_W'(1);   // natural wrap at the top
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (step_en_i) begin
      pos_q <= pos_d;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/hsg_walk_stage.sv
// One tier of the tree: its own table plus one pipeline register.
module hsg_walk_stage #(
  parameter int GROUPS  = 8,
  parameter int FANOUT  = 4,
  parameter int ENTRY_W = 8,
  parameter int POS_W   = 8,
  parameter int SHIFT   = 0,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int SEL_W  = $clog2(FANOUT),
  localparam int DEPTH  = GROUPS * FANOUT,
  localparam int ADDR_W = GRP_W + SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [GRP_W-1:0]   wr_group_i,
  input  logic [SEL_W-1:0]   wr_entry_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic               in_vld_i,
  input  logic [GRP_W-1:0]   in_grp_i,
  input  logic [POS_W-1:0]   in_pos_i,
  output logic               out_vld_o,
  output logic [ENTRY_W-1:0] out_ent_o,
  output logic [POS_W-1:0]   out_pos_o
);
  logic [ENTRY_W-1:0] table_q [DEPTH];
  logic [ADDR_W-1:0]  wr_addr, rd_addr;
  logic [SEL_W-1:0]   rd_sel;
  logic [ENTRY_W-1:0] rd_ent;

  assign wr_addr = {wr_group_i, wr_entry_i};
  assign rd_sel  = in_pos_i[SHIFT +: SEL_W];
  assign rd_addr = {in_grp_i, rd_sel};
  assign rd_ent  = table_q[rd_addr];

  // Table storage: plain write-enabled array, no reset.
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      table_q[wr_addr] <= wr_data_i;
    end
  end

  logic               vld_q, vld_d;
  logic [ENTRY_W-1:0] ent_q, ent_d;
  logic [POS_W-1:0]   pos_q, pos_d;

  always_comb begin
    vld_d = in_vld_i;
    ent_d = rd_ent;
    pos_d = in_pos_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      pos_q <= '0;
    end else if (in_vld_i) begin
      ent_q <= ent_d;
      pos_q <= pos_d;
    end
  end

  assign out_vld_o = vld_q;
  assign out_ent_o = ent_q;
  assign out_pos_o = pos_q;
endmodule

// File: rtl/hsg_note_out.sv
module hsg_note_out #(
  parameter int NOTE_W = 4
) (
  input  logic              vld_i,
  input  logic [NOTE_W-1:0] note_i,
  output logic              beat_strobe_o,
  output logic              note_valid_o,
  output logic [NOTE_W-1:0] note_o
);
  logic is_rest;

  assign is_rest       = (note_i == '0);
  assign beat_strobe_o = vld_i;
  assign note_valid_o  = vld_i & ~is_rest;
  assign note_o        = note_i;
endmodule

// File: rtl/hier_seq_gen.sv
module hier_seq_gen import hsg_pkg::*; #(
  parameter int LEVELS  = HSG_LEVELS,
  parameter int FANOUT  = HSG_FANOUT,
  parameter int GROUPS  = HSG_GROUPS,
  parameter int ENTRY_W = HSG_ENTRY_W,
  parameter int NOTE_W  = HSG_NOTE_W,
  localparam int SEL_W  = $clog2(FANOUT),
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int POS_W  = LEVELS * SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_en_i,
  input  logic [GRP_W-1:0]   score_sel_i,
  input  logic               wr_en_i,
  input  logic [LVL_W-1:0]   wr_level_i,
  input  logic [GRP_W-1:0]   wr_group_i,
  input  logic [SEL_W-1:0]   wr_entry_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  output logic               beat_strobe_o,
  output logic               note_valid_o,
  output logic [NOTE_W-1:0]  note_o
);
  logic [POS_W-1:0]   step_pos;
  logic [LEVELS:0]    c_vld;
  logic [GRP_W-1:0]   c_grp [LEVELS+1];
  logic [POS_W-1:0]   c_pos [LEVELS+1];
  logic [ENTRY_W-1:0] c_ent [LEVELS];

  hsg_step_ctr #(.POS_W(POS_W)) i_step_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_en_i(step_en_i),
    .pos_o    (step_pos)
  );

  // Head of the walk: the current position and chosen score.
  assign c_vld[LEVELS] = step_en_i;
  assign c_grp[LEVELS] = score_sel_i;
  assign c_pos[LEVELS] = step_pos;

  for (genvar k = LEVELS - 1; k >= 0; k--) begin : g_tier
    logic tier_wr;
    assign tier_wr = wr_en_i & (wr_level_i == LVL_W'(k));

    hsg_walk_stage #(
      .GROUPS (GROUPS),
      .FANOUT (FANOUT),
      .ENTRY_W(ENTRY_W),
      .POS_W  (POS_W),
      .SHIFT  (k * SEL_W)
    ) i_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (tier_wr),
      .wr_group_i(wr_group_i),
      .wr_entry_i(wr_entry_i),
      .wr_data_i (wr_data_i),
      .in_vld_i  (c_vld[k+1]),
      .in_grp_i  (c_grp[k+1]),
      .in_pos_i  (c_pos[k+1]),
      .out_vld_o (c_vld[k]),
      .out_ent_o (c_ent[k]),
      .out_pos_o (c_pos[k])
    );

    // Only the low bits of an entry steer the next tier.
    assign c_grp[k] = c_ent[k][GRP_W-1:0];

    if (k > 0) begin : g_ptr_hi
      logic hi_unused;
      assign hi_unused = ^c_ent[k][ENTRY_W-1:GRP_W];
    end
  end

  logic tail_unused;
  assign tail_unused = ^{c_grp[0], c_pos[0], c_ent[0][ENTRY_W-1:NOTE_W]};

  hsg_note_out #(.NOTE_W(NOTE_W)) i_note_out (
    .vld_i        (c_vld[0]),
    .note_i       (c_ent[0][NOTE_W-1:0]),
    .beat_strobe_o(beat_strobe_o),
    .note_valid_o (note_valid_o),
    .note_o       (note_o)
  );
endmodule

// File: rtl/hsg_checker.sv
module hsg_checker #(
  parameter int LEVELS = 4,
  parameter int NOTE_W = 4,
  parameter int POS_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              step_en_i,
  input logic              beat_strobe_o,
  input logic              note_valid_o,
  input logic [NOTE_W-1:0] note_o,
  input logic [POS_W-1:0]  pos_i
);
  logic [LEVELS-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else begin
      lat_q <= {lat_q[LEVELS-2:0], step_en_i};
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!beat_strobe_o && !note_valid_o && note_o == '0)
        else $error("outputs active during reset");
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_strobe_o == lat_q[LEVELS-1])
    else $error("strobe does not follow step request by the pipeline depth");

  p_rest_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    note_valid_o |-> (beat_strobe_o && note_o != '0))
    else $error("valid note outside a strobe or on a rest");

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> $stable(pos_i))
    else $error("position moved without a step");

  p_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i |=> pos_i == POS_W'($past(pos_i) + 1'b1))
    else $error("position did not advance by one");

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && (&pos_i)) |=> pos_i == '0)
    else $error("position did not wrap to zero");
endmodule

bind hier_seq_gen hsg_checker #(
  .LEVELS(LEVELS),
  .NOTE_W(NOTE_W),
  .POS_W (POS_W)
) i_hsg_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .step_en_i    (step_en_i),
  .beat_strobe_o(beat_strobe_o),
  .note_valid_o (note_valid_o),
  .note_o       (note_o),
  .pos_i        (step_pos)
);

// File: tb/test_hier_seq_gen.sv
module test_hier_seq_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       step_en_i;
  logic [2:0] score_sel_i;
  logic       wr_en_i;
  logic [1:0] wr_level_i;
  logic [2:0] wr_group_i;
  logic [1:0] wr_entry_i;
  logic [7:0] wr_data_i;
  logic       beat_strobe_o;
  logic       note_valid_o;
  logic [3:0] note_o;

  always #10 clk_i = ~clk_i;   // 50 MHz

  hier_seq_gen i_hier_seq_gen (
    .clk_i, .rst_ni, .step_en_i, .score_sel_i, .wr_en_i, .wr_level_i,
    .wr_group_i, .wr_entry_i, .wr_data_i, .beat_strobe_o, .note_valid_o, .note_o
  );

  int n_vec = 0;
  int n_err = 0;

  // Bench-side image of the tables and of the position.
  logic [7:0] m_tab [4][8][4];
  logic [7:0] b_pos;
  logic       hv [4];
  logic [3:0] hn [4];

  // Vector: {score[2:0], steps[9:0], mode[1:0]}
  // mode 0 every cycle, 1 every other cycle, 2 two on one off, 3 score rotates per step
  localparam logic [14:0] VEC [6] = '{
    {3'd0, 10'd300, 2'd0},
    {3'd5, 10'd40,  2'd1},
    {3'd2, 10'd60,  2'd2},
    {3'd7, 10'd50,  2'd3},
    {3'd3, 10'd70,  2'd0},
    {3'd4, 10'd30,  2'd1}
  };

  function automatic logic [3:0] model_note(input logic [2:0] sc, input logic [7:0] p);
    logic [2:0] g2, g1, g0;
    g2 = m_tab[3][sc][p[7:6]][2:0];
    g1 = m_tab[2][g2][p[5:4]][2:0];
    g0 = m_tab[1][g1][p[3:2]][2:0];
    return m_tab[0][g0][p[1:0]][3:0];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int lvl, input int g, input int e, input logic [7:0] d);
    wr_en_i = 1'b1; wr_level_i = 2'(lvl); wr_group_i = 3'(g);
    wr_entry_i = 2'(e); wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
    m_tab[lvl][g][e] = d;
  endtask

  // Called at a negedge: drive, clock, check the step issued three edges earlier.
  task automatic tick(input logic st, input logic [2:0] sc);
    step_en_i = st; score_sel_i = sc;
    for (int i = 3; i > 0; i--) begin hv[i] = hv[i-1]; hn[i] = hn[i-1]; end
    hv[0] = st;
    hn[0] = st ? model_note(sc, b_pos) : 4'd0;
    if (st) b_pos = b_pos + 8'd1;   // R7 wrap, R10 hold
    @(posedge clk_i); @(negedge clk_i);
    chk("R2 strobe", {7'd0, beat_strobe_o}, {7'd0, hv[3]});
    if (hv[3]) begin
      chk(hn[3] == 4'd0 ? "R4 rest valid" : "R3 note valid",
          {7'd0, note_valid_o}, {7'd0, hn[3] != 4'd0});
      chk("R3 note", {4'd0, note_o}, {4'd0, hn[3]});
    end else begin
      chk("R2 idle valid", {7'd0, note_valid_o}, 8'd0);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hn[i] = 4'd0; end
    b_pos = 8'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; step_en_i = 1'b0; score_sel_i = '0; wr_en_i = 1'b0;
    wr_level_i = '0; wr_group_i = '0; wr_entry_i = '0; wr_data_i = '0;
    clear_hist();
    repeat (3) @(negedge clk_i);
    // R1: quiet outputs during reset
    chk("R1 strobe", {7'd0, beat_strobe_o}, 8'd0);
    chk("R1 valid",  {7'd0, note_valid_o}, 8'd0);
    chk("R1 note",   {4'd0, note_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Fill all tables; upper bits carry junk (R5), some notes are rests (R4), R8 writes
    for (int g = 0; g < 8; g++) begin
      for (int e = 0; e < 4; e++) begin
        wr(3, g, e, {5'(g + 17 * e + 9), 3'((3 * g + e + 1) % 8)});
        wr(2, g, e, {5'(5'h1b ^ 5'(g)), 3'((g + 5 * e) % 8)});
        wr(1, g, e, {5'(5'h10 | 5'(e)), 3'((5 * g + 3 * e + 2) % 8)});
        wr(0, g, e, {4'(4'ha + 4'(g)), 4'((5 * g + 7 * e + 1) % 16)});
      end
    end

    // Vector walk: R1 first step plays position 0, R3, R6, R7 wrap, R9, R10
    for (int v = 0; v < 6; v++) begin
      for (int s = 0; s < int'(VEC[v][11:2]); ) begin
        logic st;
        logic [2:0] sc;
        case (VEC[v][1:0])
          2'd1:    st = (s % 2) == 0;
          2'd2:    st = (s % 3) != 2;
          default: st = 1'b1;
        endcase
        sc = (VEC[v][1:0] == 2'd3) ? 3'(int'(VEC[v][14:12]) + s) : VEC[v][14:12];
        tick(st, sc);
        s++;
      end
    end
    repeat (4) tick(1'b0, 3'd0);

    // R8: rewrite a few entries in place, replay score 6 across all its bars
    wr(3, 6, 2, 8'hf9);                 // points to group 1 (R5 junk bits)
    wr(0, 4, 3, 8'h50);                 // becomes a rest (R4)
    wr(1, 7, 0, 8'h0c);
    for (int s = 0; s < 256; s++) tick(1'b1, 3'd6);
    repeat (4) tick(1'b0, 3'd0);

    // R1: reset with notes in flight clears pipeline and position
    tick(1'b1, 3'd1); tick(1'b1, 3'd1);
    rst_ni = 1'b0;
    #1;
    chk("R1 flush strobe", {7'd0, beat_strobe_o}, 8'd0);
    @(negedge clk_i);
    chk("R1 flush valid", {7'd0, note_valid_o}, 8'd0);
    rst_ni = 1'b1;
    clear_hist();
    for (int s = 0; s < 12; s++) tick(1'b1, 3'd1);
    repeat (4) tick(1'b0, 3'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule